// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

A 32-bit processor core that completes one instruction in every clock cycle. It supports six instructions: register add, add-immediate, load word, store word, branch-if-equal and absolute jump. The core holds the program counter, a 32-entry register file, a sign extender, and an ALU that either adds or tests two operands for equality. A combinational decoder turns the opcode into eight control lines. These lines steer the destination-register mux, the second-operand mux, the write-back mux and the two next-PC muxes, and they gate the register-file and data-memory writes.

Instruction memory and data memory are 256-word arrays inside the core, indexed by address bits [9:2]. The program is loaded through a write port while reset is held. After reset is released, execution starts at address 0. Each cycle's register write-back, data-memory write and current PC appear on output ports, so the effect of every instruction can be observed.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and both rf_we_o and dm_we_o are 0. Load-port writes (load_we_i) store load_data_i into instruction word load_addr_i.
- R2: add (opcode 0x00, funct 0x20, rs=[25:21], rt=[20:16], rd=[15:11]) writes rs+rt to rd and advances the PC by 4.
- R3: addi (opcode 0x08) writes rs plus the 16-bit immediate [15:0], sign-extended from bit 15, to rt.
- R4: sw (opcode 0x2B) writes register rt to data memory at address rs+sext(imm). dm_addr_o and dm_wdata_o show that address and data with dm_we_o high, and no register is written.
- R5: lw (opcode 0x23) writes the data-memory word at rs+sext(imm) to rt.
- R6: beq (opcode 0x04) sets the next PC to PC+4+(sext(imm)<<2) when rs equals rt, and to PC+4 otherwise. It writes neither registers nor memory.
- R7: j (opcode 0x02) sets the next PC to {PC+4[31:28], target[25:0], 2'b00} and writes nothing.
- R8: Register 0 reads as zero. A write to it is still shown on rf_we_o, but it leaves the register at zero.
- R9: Any other opcode, or opcode 0x00 with a funct other than 0x20, executes as a no-op. It writes nothing and the PC advances by 4.
- R10: A register or memory word written in one cycle is seen by the instruction in the next cycle. The PC always stays word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_we_i | input | 1 | Instruction memory load strobe |
| load_addr_i | input | 8 | Instruction word index to load |
| load_data_i | input | 32 | Instruction word to load |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write this cycle |
| rf_waddr_o | output | 5 | Destination register |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Data memory write this cycle |
| dm_addr_o | output | 32 | Data memory byte address (ALU sum) |
| dm_wdata_o | output | 32 | Data memory store value |

## Verification
Two cases are hardest to reach from the ports: a load that reads a word stored one cycle earlier, and a taken branch whose comparison uses a value that came back through memory. The stimulus stores the sum of two random immediates, one of them negative, reloads it at once and branches on equality with the original register. The same program also writes register 0 and stores it, uses a negative store offset, and includes two undefined encodings and a jump. It is rerun with several sets of random operands, and an instruction-level model in the bench predicts every cycle's write-back, store and PC.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_J     = 6'h02;
  localparam logic [5:0] FN_ADD    = 6'h20;

  typedef struct packed {
    logic dst_rd;   // 1: rd, 0: rt
    logic rf_we;
    logic b_imm;    // 1: second operand is sext immediate
    logic op_eq;    // 0: add, 1: equality
    logic dm_we;
    logic wb_mem;   // 1: write back memory word
    logic br;
    logic jp;
  } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [5:0] opc_i,
  input  logic [5:0] fn_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (opc_i)
      OPC_RTYPE: if (fn_i == FN_ADD) begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.rf_we  = 1'b1;
      end
      OPC_ADDI: begin
        ctrl_o.rf_we = 1'b1;
        ctrl_o.b_imm = 1'b1;
      end
      OPC_LW: begin
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.wb_mem = 1'b1;
      end
      OPC_SW: begin
        ctrl_o.b_imm = 1'b1;
        ctrl_o.dm_we = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.op_eq = 1'b1;
        ctrl_o.br    = 1'b1;
      end
      OPC_J: ctrl_o.jp = 1'b1;
      default: ctrl_o = '0;
    endcase
  end

  // a store never also writes back
  assert_store_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_o.rf_we, ctrl_o.dm_we}));
  // branch always compares
  assert_br_eq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.br |-> ctrl_o.op_eq && !ctrl_o.rf_we && !ctrl_o.dm_we);
endmodule

// File: rtl/sc_alu.sv
module sc_alu #(
  parameter int W = 32
) (
  input  logic         op_eq_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    if (op_eq_i) y_o = {{(W-1){1'b0}}, a_i == b_i};
    else         y_o = a_i + b_i;
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign rd_a_o = (ra_a_i == '0) ? '0 : regs_q[ra_a_i];
  assign rd_b_o = (ra_b_i == '0) ? '0 : regs_q[ra_b_i];

  assert_r0_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_a_i == '0) |-> (rd_a_o == '0));
  assert_wr_visible_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0) |=> (regs_q[$past(wa_i)] == $past(wd_i)));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int MEM_AW = 8,
  parameter int NREG   = 32,
  localparam int RAW   = $clog2(NREG),
  localparam int DEPTH = 2 ** MEM_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_we_i,
  input  logic [MEM_AW-1:0] load_addr_i,
  input  logic [XLEN-1:0]   load_data_i,
  output logic [XLEN-1:0]   pc_o,
  output logic              rf_we_o,
  output logic [RAW-1:0]    rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              dm_we_o,
  output logic [XLEN-1:0]   dm_addr_o,
  output logic [XLEN-1:0]   dm_wdata_o
);
  logic [XLEN-1:0] imem [DEPTH];
  logic [XLEN-1:0] dmem [DEPTH];
  logic [XLEN-1:0] pc_q, pc_plus4, pc_br, pc_next, instr;
  logic [XLEN-1:0] imm_sx, rs_val, rt_val, alu_b, alu_y, dm_rdata;
  logic            br_taken;
  ctrl_t           ctrl;

  assign instr    = imem[pc_q[MEM_AW+1:2]];
  assign pc_plus4 = pc_q + XLEN'(4);
  assign imm_sx   = {{(XLEN-16){instr[15]}}, instr[15:0]};

  always_ff @(posedge clk_i) begin
    if (load_we_i) imem[load_addr_i] <= load_data_i;
  end

  sc_decoder u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .opc_i (instr[31:26]),
    .fn_i  (instr[5:0]),
    .ctrl_o(ctrl)
  );

  sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra_a_i(instr[25:21]),
    .ra_b_i(instr[20:16]),
    .rd_a_o(rs_val),
    .rd_b_o(rt_val),
    .we_i  (rf_we_o),
    .wa_i  (rf_waddr_o),
    .wd_i  (rf_wdata_o)
  );

  assign alu_b = ctrl.b_imm ? imm_sx : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .op_eq_i(ctrl.op_eq),
    .a_i    (rs_val),
    .b_i    (alu_b),
    .y_o    (alu_y)
  );

  assign dm_rdata = dmem[alu_y[MEM_AW+1:2]];
  always_ff @(posedge clk_i) begin
    if (dm_we_o) dmem[alu_y[MEM_AW+1:2]] <= rt_val;
  end

  assign rf_we_o    = ctrl.rf_we & rst_ni;
  assign rf_waddr_o = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_wdata_o = ctrl.wb_mem ? dm_rdata : alu_y;
  assign dm_we_o    = ctrl.dm_we & rst_ni;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_val;

  // next PC: branch mux then jump mux
  assign br_taken = ctrl.br & alu_y[0];
  assign pc_br    = br_taken ? pc_plus4 + {imm_sx[XLEN-3:0], 2'b00} : pc_plus4;
  assign pc_next  = ctrl.jp ? {pc_plus4[XLEN-1:XLEN-4], instr[25:0], 2'b00} : pc_br;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end
  assign pc_o = pc_q;

  // assertions
  logic known_op;
  assign known_op = (instr[31:26] == 6'h00 && instr[5:0] == 6'h20) ||
                    instr[31:26] inside {6'h08, 6'h23, 6'h2B, 6'h04, 6'h02};

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_pc_R1: assert (pc_q == '0 && !rf_we_o && !dm_we_o);
    end
  end

  assert_jump_tgt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr[31:26] == 6'h02) |=>
      (pc_q == {$past(pc_plus4[XLEN-1:XLEN-4]), $past(instr[25:0]), 2'b00}));
  assert_nop_writes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known_op |-> (!rf_we_o && !dm_we_o));
  assert_nop_pc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known_op |=> (pc_q == $past(pc_q) + XLEN'(4)));
  assert_pc_align_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q[1:0] == 2'b00);
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc, rf_wd, dm_a, dm_wd;
  logic        rf_we, dm_we;
  logic [4:0]  rf_wa;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sc_core u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .load_we_i(ld_we), .load_addr_i(ld_addr), .load_data_i(ld_data),
    .pc_o(pc), .rf_we_o(rf_we), .rf_waddr_o(rf_wa), .rf_wdata_o(rf_wd),
    .dm_we_o(dm_we), .dm_addr_o(dm_a), .dm_wdata_o(dm_wd)
  );

  logic [31:0] prog [32];
  logic [31:0] mreg [32];
  logic [31:0] mmem [256];
  logic [31:0] mpc;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
  function automatic string req_of(logic [31:0] ins);
    case (ins[31:26])
      6'h00: return (ins[5:0] == 6'h20) ? ((ins[15:11] == 0) ? "R8" : "R2") : "R9";
      6'h08: return (ins[20:16] == 0) ? "R8" : "R3";
      6'h2B: return "R4";
      6'h23: return "R5";
      6'h04: return "R6";
      6'h02: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model: compare this cycle's outputs, then advance
  task automatic step_and_check();
    logic [31:0] ins, a, b, e_wd, e_pc, e_addr;
    logic        e_rwe, e_dwe;
    logic [4:0]  e_wa;
    string       rq;
    ins = prog[mpc[6:2]];
    rq  = req_of(ins);
    a = mreg[ins[25:21]];
    b = mreg[ins[20:16]];
    e_rwe = 1'b0; e_dwe = 1'b0; e_wa = ins[20:16]; e_wd = '0; e_addr = a + sx(ins[15:0]);
    e_pc = mpc + 4;
    case (ins[31:26])
      6'h00: if (ins[5:0] == 6'h20) begin e_rwe = 1; e_wa = ins[15:11]; e_wd = a + b; end
      6'h08: begin e_rwe = 1; e_wd = e_addr; end
      6'h23: begin e_rwe = 1; e_wd = mmem[e_addr[9:2]]; end
      6'h2B: e_dwe = 1;
      6'h04: if (a == b) e_pc = mpc + 4 + {sx(ins[15:0])[29:0], 2'b00};
      6'h02: e_pc = {e_pc[31:28], ins[25:0], 2'b00};
      default: ;
    endcase
    chk(rq, "pc", pc, mpc);
    chk(rq, "rf_we", 32'(rf_we), 32'(e_rwe));
    if (e_rwe) begin
      chk(rq, "rf_waddr", 32'(rf_wa), 32'(e_wa));
      chk(rq, "rf_wdata", rf_wd, e_wd);
      if (e_wa != 0) mreg[e_wa] = e_wd;
    end
    chk(rq, "dm_we", 32'(dm_we), 32'(e_dwe));
    if (e_dwe) begin
      chk(rq, "dm_addr", dm_a, e_addr);
      chk(rq, "dm_wdata", dm_wd, b);
      mmem[e_addr[9:2]] = b;
    end
    mpc = e_pc;
  endtask

  task automatic build(logic [15:0] ia, logic [15:0] ib);
    for (int i = 0; i < 32; i++) prog[i] = 32'hFC00_0000;      // undefined opcode
    prog[0]  = enc_i(6'h08, 0, 1, ia);                        // R3
    prog[1]  = enc_i(6'h08, 0, 2, ib);                        // R3 negative imm
    prog[2]  = enc_r(1, 2, 3, 6'h20);                         // R2
    prog[3]  = enc_i(6'h2B, 0, 3, 16'd8);                     // R4
    prog[4]  = enc_i(6'h23, 0, 4, 16'd8);                     // R5, R10
    prog[5]  = enc_r(4, 0, 5, 6'h20);                         // R8 read r0
    prog[6]  = enc_i(6'h08, 1, 0, 16'd5);                     // R8 write r0
    prog[7]  = enc_i(6'h2B, 0, 0, 16'd12);                    // R8 store r0
    prog[8]  = enc_i(6'h04, 1, 2, 16'd5);                     // R6 not taken
    prog[9]  = enc_i(6'h04, 4, 3, 16'd2);                     // R6 taken
    prog[10] = enc_i(6'h08, 0, 6, 16'd1);
    prog[11] = enc_i(6'h08, 0, 6, 16'd2);
    prog[12] = 32'hFC00_1234;                                 // R9 bad opcode
    prog[13] = enc_r(1, 2, 6, 6'h22);                         // R9 bad funct
    prog[14] = enc_i(6'h08, 0, 7, 16'h0040);
    prog[15] = enc_i(6'h2B, 7, 5, 16'hFFFC);                  // R4 negative offset
    prog[16] = enc_i(6'h23, 7, 8, 16'hFFFC);                  // R5
    prog[17] = {6'h02, 26'd20};                               // R7
    prog[18] = enc_i(6'h08, 0, 9, 16'd7);
    prog[19] = enc_i(6'h08, 0, 9, 16'd8);
    prog[20] = enc_i(6'h04, 0, 0, 16'hFFFF);                  // self loop
  endtask

  task automatic run_prog(logic [15:0] ia, logic [15:0] ib, int cycles);
    build(ia, ib);
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 8'(i); ld_data = prog[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
    #1;
    chk("R1", "pc in reset", pc, 32'h0);
    chk("R1", "rf_we in reset", 32'(rf_we), 32'h0);
    chk("R1", "dm_we in reset", 32'(dm_we), 32'h0);
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    mpc = '0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      #1;
      step_and_check();
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // directed corners: extreme immediates
    run_prog(16'h7FFF, 16'h8000, 26);
    run_prog(16'h0001, 16'hFFFF, 26);
    for (int k = 0; k < 4; k++) begin
      run_prog(16'($urandom_range(1, 16'h7FFF)),
               16'h8000 | 16'($urandom_range(0, 16'h7FFF)), 26);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule